// File: doc/BRIEF.md
# Workspace Context Switch Sequencer

This block switches register contexts for a processor whose sixteen general registers live in external RAM at the address held in a workspace pointer (WP). Nothing is pushed to a stack. A switch reads a two-word vector, which gives a new WP and then a new PC. It then stores the old WP, PC and status (ST) into registers 13, 14 and 15 of the new workspace. A return reads those three words back from the current workspace, ST first and WP last. Register n of a workspace sits at byte address WP + 2n. Words are big-endian. ST bit 0 is the most significant bit, so the interrupt mask in ST bits 12–15 is the low nibble of the ST word.

Five requests can start a sequence:
- a forced load through a dedicated vector;
- a maskable interrupt with a 4-bit priority code;
- a return;
- a vectored call with an explicit vector address;
- a trap with a 4-bit number. A trap also stores a supplied effective address into register 11 of the new workspace.

All accesses go through one word-wide memory port with a ready handshake. An access completes in any cycle where both the request and `mem_rdy` are high. The updated WP, PC and ST appear on the outputs only when the whole sequence has finished.

Top module: `wp_ctx_seq`

## Requirements
- R1: After reset, `wp`, `pc` and `st` are 0, `busy` is 0 and `mem_req` is low.
- R2: A call with vector address V reads the new WP from V and the new PC from V+2. It then writes the old WP, PC and ST to new-WP+26, +28 and +30, in that order. At the end, WP and PC take the new values and ST is unchanged.
- R3: A return reads current-WP+30, +28 and +26, in that order. It then loads those three words into ST, PC and WP.
- R4: A trap with number n uses vector SW_BASE + 4n (default 0x0040). After the three saves, it makes a fourth write of the effective address to new-WP+22.
- R5: An interrupt with code c is served when c is not above the mask (ST[3:0]); code 0 is the most urgent. It uses vector HW_BASE + 4c (default 0x0000). The old ST is saved as it was. The new mask becomes c−1 (0 when c is 0), so a second request with the same code is held off.
- R6: An interrupt whose code is above the mask causes no memory access and no change to `busy`, `wp`, `pc` or `st`.
- R7: A load request uses vector LOAD_VEC (default 0xFFFC) whatever the mask, and leaves ST unchanged.
- R8: `busy` rises on the clock edge that accepts a request and falls on the edge that completes the last access. With `mem_rdy` held high, `busy` lasts 5 cycles for a load, interrupt or call, 6 cycles for a trap and 3 cycles for a return. `wp`, `pc` and `st` do not change while `busy` is high.
- R9: Requests that arrive while `busy` is high are ignored.
- R10: While `mem_rdy` is low, the address, direction and write data stay stable, and the sequence waits.
- R11: When several requests are present at once, the priority is load, then a servable interrupt, then return, then call, then trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_req | input | 1 | Forced load request |
| irq_req | input | 1 | Maskable interrupt request |
| irq_code | input | 4 | Interrupt priority code, 0 most urgent |
| ret_req | input | 1 | Return request |
| call_req | input | 1 | Vectored call request |
| call_vec | input | 16 | Byte address of the call vector |
| xop_req | input | 1 | Trap request |
| xop_num | input | 4 | Trap number |
| xop_ea | input | 16 | Effective address stored in register 11 by a trap |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid while `mem_rdy` is high |
| mem_rdy | input | 1 | Access completes this cycle |
| busy | output | 1 | Sequence in progress |
| wp | output | 16 | Workspace pointer |
| pc | output | 16 | Program counter |
| st | output | 16 | Status word |

## Verification
Requests are driven on the falling edge and are accepted on the next rising edge, so `busy` is first seen half a cycle later. With `mem_rdy` held high, the bench counts falling edges with `busy` high and compares the count with the 5, 6 or 3 cycles that R8 sets for each kind. The new WP, PC and ST are read on the first falling edge with `busy` low, which follows the edge that completed the last access. The access log is compared entry by entry at the same point. For a masked interrupt, the bench looks at the falling edge after acceptance would have happened and checks that `busy` is still 0 and no access was logged. In the phase with random `mem_rdy`, the cycle-count check is dropped. The order of the accesses and the final register values are still checked.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    typedef enum logic [2:0] {
        K_LOAD,
        K_IRQ,
        K_RET,
        K_CALL,
        K_XOP
    } kind_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RWP,
        S_RPC,
        S_W13,
        S_W14,
        S_W15,
        S_W11,
        S_R15,
        S_R14,
        S_R13
    } step_e;

    // byte offset of workspace register n
    function automatic int unsigned reg_byte(input int unsigned n);
        return 2 * n;
    endfunction

endpackage

// File: rtl/wcs_arbiter.sv
module wcs_arbiter
    import wcs_pkg::*;
#(
    parameter int W              = 16,
    parameter int LVL_W          = 4,
    parameter int unsigned HW_BASE  = 32'h0000,
    parameter int unsigned SW_BASE  = 32'h0040,
    parameter int unsigned LOAD_VEC = 32'hFFFC
) (
    input  logic             load_req,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_code,
    input  logic [LVL_W-1:0] mask,
    input  logic             ret_req,
    input  logic             call_req,
    input  logic [W-1:0]     call_vec,
    input  logic             xop_req,
    input  logic [LVL_W-1:0] xop_num,
    output logic             take,
    output kind_e            kind,
    output logic [W-1:0]     vec,
    output logic [LVL_W-1:0] new_mask
);
    logic irq_ok;

    assign irq_ok   = irq_req && (irq_code <= mask);
    assign new_mask = (irq_code == '0) ? '0 : irq_code - 1'b1;

    always_comb begin
        take = 1'b1;
        kind = K_XOP;
        vec  = W'(SW_BASE) + (W'(xop_num) << 2);
        if (load_req) begin
            kind = K_LOAD;
            vec  = W'(LOAD_VEC);
        end else if (irq_ok) begin
            kind = K_IRQ;
            vec  = W'(HW_BASE) + (W'(irq_code) << 2);
        end else if (ret_req) begin
            kind = K_RET;
            vec  = '0;
        end else if (call_req) begin
            kind = K_CALL;
            vec  = call_vec;
        end else if (!xop_req) begin
            take = 1'b0;
        end
    end

endmodule

// File: rtl/wcs_port_map.sv
module wcs_port_map
    import wcs_pkg::*;
#(
    parameter int W = 16
) (
    input  step_e        step,
    input  logic [W-1:0] vec,
    input  logic [W-1:0] cur_wp,
    input  logic [W-1:0] cur_pc,
    input  logic [W-1:0] cur_st,
    input  logic [W-1:0] new_wp,
    input  logic [W-1:0] ea,
    output logic         req,
    output logic         we,
    output logic [W-1:0] addr,
    output logic [W-1:0] wdata
);
    localparam logic [W-1:0] OFS_LINK = W'(reg_byte(11));
    localparam logic [W-1:0] OFS_OWP  = W'(reg_byte(13));
    localparam logic [W-1:0] OFS_OPC  = W'(reg_byte(14));
    localparam logic [W-1:0] OFS_OST  = W'(reg_byte(15));

    always_comb begin
        req   = 1'b1;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        unique case (step)
            S_RWP: addr = vec;
            S_RPC: addr = vec + W'(2);
            S_W13: begin we = 1'b1; addr = new_wp + OFS_OWP;  wdata = cur_wp; end
            S_W14: begin we = 1'b1; addr = new_wp + OFS_OPC;  wdata = cur_pc; end
            S_W15: begin we = 1'b1; addr = new_wp + OFS_OST;  wdata = cur_st; end
            S_W11: begin we = 1'b1; addr = new_wp + OFS_LINK; wdata = ea;     end
            S_R15: addr = cur_wp + OFS_OST;
            S_R14: addr = cur_wp + OFS_OPC;
            S_R13: addr = cur_wp + OFS_OWP;
            default: req = 1'b0;
        endcase
    end

endmodule

// File: rtl/wp_ctx_seq.sv
module wp_ctx_seq
    import wcs_pkg::*;
#(
    parameter int W              = 16,
    parameter int LVL_W          = 4,
    parameter int unsigned HW_BASE  = 32'h0000,
    parameter int unsigned SW_BASE  = 32'h0040,
    parameter int unsigned LOAD_VEC = 32'hFFFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_req,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_code,
    input  logic             ret_req,
    input  logic             call_req,
    input  logic [W-1:0]     call_vec,
    input  logic             xop_req,
    input  logic [LVL_W-1:0] xop_num,
    input  logic [W-1:0]     xop_ea,
    output logic             mem_req,
    output logic             mem_we,
    output logic [W-1:0]     mem_addr,
    output logic [W-1:0]     mem_wdata,
    input  logic [W-1:0]     mem_rdata,
    input  logic             mem_rdy,
    output logic             busy,
    output logic [W-1:0]     wp,
    output logic [W-1:0]     pc,
    output logic [W-1:0]     st
);
    typedef struct packed {
        step_e        step;
        kind_e        kind;
        logic [W-1:0] vec;
        logic [W-1:0] wp;
        logic [W-1:0] pc;
        logic [W-1:0] st;
        logic [W-1:0] nwp;
        logic [W-1:0] npc;
        logic [W-1:0] nst;
        logic [W-1:0] ea;
    } seq_t;

    seq_t q, d;

    logic             take;
    kind_e            a_kind;
    logic [W-1:0]     a_vec;
    logic [LVL_W-1:0] a_mask;

    wcs_arbiter #(
        .W(W), .LVL_W(LVL_W), .HW_BASE(HW_BASE), .SW_BASE(SW_BASE), .LOAD_VEC(LOAD_VEC)
    ) u_arb (
        .load_req (load_req),
        .irq_req  (irq_req),
        .irq_code (irq_code),
        .mask     (q.st[LVL_W-1:0]),
        .ret_req  (ret_req),
        .call_req (call_req),
        .call_vec (call_vec),
        .xop_req  (xop_req),
        .xop_num  (xop_num),
        .take     (take),
        .kind     (a_kind),
        .vec      (a_vec),
        .new_mask (a_mask)
    );

    wcs_port_map #(.W(W)) u_map (
        .step   (q.step),
        .vec    (q.vec),
        .cur_wp (q.wp),
        .cur_pc (q.pc),
        .cur_st (q.st),
        .new_wp (q.nwp),
        .ea     (q.ea),
        .req    (mem_req),
        .we     (mem_we),
        .addr   (mem_addr),
        .wdata  (mem_wdata)
    );

    always_comb begin
        d = q;
        unique case (q.step)
            S_IDLE: begin
                if (take) begin
                    d.kind = a_kind;
                    d.vec  = a_vec;
                    d.ea   = xop_ea;
                    d.nst  = q.st;
                    if (a_kind == K_IRQ) d.nst[LVL_W-1:0] = a_mask;
                    d.step = (a_kind == K_RET) ? S_R15 : S_RWP;
                end
            end
            S_RWP: if (mem_rdy) begin d.nwp = mem_rdata; d.step = S_RPC; end
            S_RPC: if (mem_rdy) begin d.npc = mem_rdata; d.step = S_W13; end
            S_W13: if (mem_rdy) d.step = S_W14;
            S_W14: if (mem_rdy) d.step = S_W15;
            S_W15: begin
                if (mem_rdy) begin
                    if (q.kind == K_XOP) begin
                        d.step = S_W11;
                    end else begin
                        d.wp = q.nwp; d.pc = q.npc; d.st = q.nst; d.step = S_IDLE;
                    end
                end
            end
            S_W11: if (mem_rdy) begin
                d.wp = q.nwp; d.pc = q.npc; d.st = q.nst; d.step = S_IDLE;
            end
            S_R15: if (mem_rdy) begin d.nst = mem_rdata; d.step = S_R14; end
            S_R14: if (mem_rdy) begin d.npc = mem_rdata; d.step = S_R13; end
            S_R13: if (mem_rdy) begin
                d.wp = mem_rdata; d.pc = q.npc; d.st = q.nst; d.step = S_IDLE;
            end
            default: d.step = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = (q.step != S_IDLE);
    assign wp   = q.wp;
    assign pc   = q.pc;
    assign st   = q.st;

    // R1: no memory traffic while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R8: visible context frozen for the whole sequence
    a_r8_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($stable(wp) && $stable(pc) && $stable(st)));

    // R10: a stalled access keeps its address, direction and data
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R7: a load request is always taken when idle
    a_r7_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load_req) |=> (busy && q.kind == K_LOAD));

    // R6: a masked interrupt alone starts nothing
    a_r6_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && irq_req && (irq_code > st[LVL_W-1:0]) && !load_req && !ret_req && !call_req && !xop_req)
        |=> !busy);

    // R9: once busy, the sequence is never restarted from idle state
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_rdy) |=> busy);

endmodule

// File: tb/wp_ctx_seq_tb.sv
module wp_ctx_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_req = 1'b0, irq_req = 1'b0, ret_req = 1'b0, call_req = 1'b0, xop_req = 1'b0;
    logic [3:0]  irq_code = '0, xop_num = '0;
    logic [15:0] call_vec = '0, xop_ea = '0;
    logic        mem_req, mem_we, busy;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, wp, pc, st;
    logic        mem_rdy = 1'b1;
    bit          rnd_rdy = 1'b0;

    int tests = 0, fails = 0;

    always #5 clk = ~clk;

    wp_ctx_seq u_dut (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .irq_req(irq_req), .irq_code(irq_code),
        .ret_req(ret_req), .call_req(call_req), .call_vec(call_vec), .xop_req(xop_req),
        .xop_num(xop_num), .xop_ea(xop_ea), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .busy(busy), .wp(wp), .pc(pc), .st(st)
    );

    // memory model: 4 KB, aliased; logs every completed access
    logic [15:0] mem [0:2047];
    logic        bw_en = 1'b0;
    logic [15:0] bw_a = '0, bw_d = '0;
    logic        lg_we [0:15];
    logic [15:0] lg_a [0:15];
    logic [15:0] lg_d [0:15];
    int          lg_n;

    assign mem_rdata = mem[mem_addr[11:1]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) mem[i] <= 16'h0;
            lg_n <= 0;
        end else if (mem_req && mem_rdy) begin
            lg_we[lg_n % 16] <= mem_we;
            lg_a[lg_n % 16]  <= mem_addr;
            lg_d[lg_n % 16]  <= mem_we ? mem_wdata : mem_rdata;
            lg_n <= lg_n + 1;
            if (mem_we) mem[mem_addr[11:1]] <= mem_wdata;
        end else if (bw_en) begin
            mem[bw_a[11:1]] <= bw_d;
        end
    end

    always @(negedge clk) mem_rdy = rnd_rdy ? (($urandom % 4) != 0) : 1'b1;

    // reference model
    logic [15:0] m_wp = '0, m_pc = '0, m_st = '0;
    logic        e_we [0:7];
    logic [15:0] e_a [0:7];
    logic [15:0] e_d [0:7];
    int          e_n;

    function automatic logic [15:0] rdm(input logic [15:0] a);
        return mem[a[11:1]];
    endfunction

    function automatic logic [3:0] drop_mask(input logic [3:0] c);
        return (c == 4'd0) ? 4'd0 : c - 4'd1;
    endfunction

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] v);
        bw_en = 1'b1; bw_a = a; bw_d = v;
        tick;
        bw_en = 1'b0;
    endtask

    task automatic add_exp(input logic w, input logic [15:0] a, input logic [15:0] v);
        e_we[e_n] = w; e_a[e_n] = a; e_d[e_n] = v; e_n++;
    endtask

    // rq bits: [4] load, [3] irq, [2] ret, [1] call, [0] trap
    task automatic do_op(input logic [4:0] rq, input logic [3:0] code, input logic [15:0] cv,
                         input logic [3:0] num, input logic [15:0] ea, input bit inj, input string tag);
        int k, n, base, expn;
        bit chg, ok;
        logic [15:0] v, nw, np, nst, ow, op, os;
        if (rq[4]) k = 1;
        else if (rq[3] && code <= m_st[3:0]) k = 2;
        else if (rq[2]) k = 3;
        else if (rq[1]) k = 4;
        else if (rq[0]) k = 5;
        else k = 0;
        case (k)
            1: v = 16'hFFFC;
            2: v = {10'd0, code, 2'b00};
            4: v = cv;
            5: v = 16'h0040 + {10'd0, num, 2'b00};
            default: v = '0;
        endcase
        e_n = 0; expn = 0;
        nw = m_wp; np = m_pc; nst = m_st;
        if (k == 1 || k == 2 || k == 4 || k == 5) begin
            nw = 16'h0100 + 16'(($urandom % 112) * 32);
            np = 16'($urandom) & 16'hFFFE;
            poke(v, nw);
            poke(v + 16'd2, np);
            add_exp(1'b0, v, nw);
            add_exp(1'b0, v + 16'd2, np);
            add_exp(1'b1, nw + 16'd26, m_wp);
            add_exp(1'b1, nw + 16'd28, m_pc);
            add_exp(1'b1, nw + 16'd30, m_st);
            if (k == 5) add_exp(1'b1, nw + 16'd22, ea);
            if (k == 2) nst = {m_st[15:4], drop_mask(code)};
            expn = (k == 5) ? 6 : 5;
        end else if (k == 3) begin
            nst = rdm(m_wp + 16'd30);
            np  = rdm(m_wp + 16'd28);
            nw  = rdm(m_wp + 16'd26);
            add_exp(1'b0, m_wp + 16'd30, nst);
            add_exp(1'b0, m_wp + 16'd28, np);
            add_exp(1'b0, m_wp + 16'd26, nw);
            expn = 3;
        end
        ow = wp; op = pc; os = st;
        base = lg_n;
        load_req = rq[4]; irq_req = rq[3]; irq_code = code; ret_req = rq[2];
        call_req = rq[1]; call_vec = cv; xop_req = rq[0]; xop_num = num; xop_ea = ea;
        tick;
        load_req = 0; irq_req = 0; ret_req = 0; call_req = 0; xop_req = 0;
        n = 0; chg = 0;
        while (busy && n < 300) begin
            n++;
            if (wp !== m_wp || pc !== m_pc || st !== m_st) chg = 1;
            if (inj) load_req = (n == 1);
            tick;
        end
        load_req = 0;
        if (k == 0) begin
            chk(n == 0, {tag, " R6 no busy"}, 16'(n), 16'd0);
            chk(lg_n == base, {tag, " R6 no access"}, 16'(lg_n - base), 16'd0);
            chk(wp == ow && pc == op && st == os, {tag, " R6 regs kept"}, st, os);
        end else begin
            if (!rnd_rdy) chk(n == expn, {tag, " R8 busy cycles"}, 16'(n), 16'(expn));
            chk(!chg, {tag, " R8 regs stable while busy"}, wp, m_wp);
            chk(lg_n - base == e_n, {tag, " access count"}, 16'(lg_n - base), 16'(e_n));
            ok = 1;
            for (int i = 0; i < e_n; i++) begin
                if (lg_we[(base + i) % 16] !== e_we[i] || lg_a[(base + i) % 16] !== e_a[i] ||
                    lg_d[(base + i) % 16] !== e_d[i]) ok = 0;
            end
            chk(ok, {tag, " access order"}, lg_a[base % 16], e_a[0]);
            m_wp = nw; m_pc = np; m_st = nst;
            chk(wp === m_wp, {tag, " wp"}, wp, m_wp);
            chk(pc === m_pc, {tag, " pc"}, pc, m_pc);
            chk(st === m_st, {tag, " st"}, st, m_st);
        end
        if (inj) begin
            tick;
            chk(!busy && lg_n == base + e_n, {tag, " R9 busy request ignored"}, 16'(lg_n - base), 16'(e_n));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        // R1
        chk(wp == 0 && pc == 0 && st == 0, "R1 reset regs", st, 16'h0);
        chk(!busy && !mem_req, "R1 reset idle", {14'd0, busy, mem_req}, 16'h0);

        do_op(5'b10000, 4'd0, 16'h0, 4'd0, 16'h0, 0, "R7 load");
        do_op(5'b00010, 4'd0, 16'h0084, 4'd0, 16'h0, 0, "R2 call");
        do_op(5'b00001, 4'd9, 16'h0, 4'd9, 16'hBEEF, 0, "R4 trap");
        do_op(5'b00100, 4'd0, 16'h0, 4'd0, 16'h0, 0, "R3 return");

        // craft a frame so that a return sets mask 5
        poke(m_wp + 16'd26, 16'h0200);
        poke(m_wp + 16'd28, 16'h1234);
        poke(m_wp + 16'd30, 16'h0005);
        do_op(5'b00100, 4'd0, 16'h0, 4'd0, 16'h0, 0, "R3 return sets mask");
        do_op(5'b01000, 4'd7, 16'h0, 4'd0, 16'h0, 0, "R6 masked code 7");
        do_op(5'b01000, 4'd5, 16'h0, 4'd0, 16'h0, 0, "R5 code 5 served");
        do_op(5'b01000, 4'd5, 16'h0, 4'd0, 16'h0, 0, "R5 equal code held off");
        do_op(5'b01000, 4'd2, 16'h0, 4'd0, 16'h0, 0, "R5 nested code 2");
        do_op(5'b00100, 4'd0, 16'h0, 4'd0, 16'h0, 0, "R3 nested return");
        do_op(5'b11000, 4'd0, 16'h0, 4'd0, 16'h0, 0, "R11 load over irq");
        do_op(5'b01010, 4'd0, 16'h0090, 4'd0, 16'h0, 0, "R11 irq over call");
        do_op(5'b00110, 4'd0, 16'h0094, 4'd0, 16'h0, 0, "R11 return over call");
        do_op(5'b00011, 4'd0, 16'h0098, 4'd3, 16'h1111, 0, "R11 call over trap");
        do_op(5'b00010, 4'd0, 16'h00A0, 4'd0, 16'h0, 1, "R9 call with injected load");

        for (int i = 0; i < 160; i++) begin
            int sel;
            rnd_rdy = (i >= 80);
            sel = $urandom % 7;
            case (sel)
                0: do_op(5'b10000, 4'd0, 16'h0, 4'd0, 16'h0, 0, "R7 rnd load");
                1, 2: do_op(5'b01000, 4'($urandom), 16'h0, 4'd0, 16'h0, 0, "R5 rnd irq");
                3: do_op(5'b00100, 4'd0, 16'h0, 4'd0, 16'h0, 0, "R3 rnd return");
                4: do_op(5'b00010, 4'd0, 16'h0080 + 16'(($urandom % 32) * 4), 4'd0, 16'h0, 0,
                         rnd_rdy ? "R10 rnd call" : "R2 rnd call");
                5: do_op(5'b00001, 4'd0, 16'h0, 4'($urandom), 16'($urandom), 0, "R4 rnd trap");
                default: do_op(5'($urandom), 4'($urandom), 16'h0080 + 16'(($urandom % 32) * 4),
                               4'($urandom), 16'($urandom), 0, "R11 rnd mix");
            endcase
        end
        rnd_rdy = 0;
        tick;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule